// File: doc/BRIEF.md
# 2B1Q Line Symbol Framer with Self-Synchronizing Scrambler

This block produces the transmit symbol stream of a 2B1Q subscriber line transceiver. On every symbol-enable pulse it emits one quaternary symbol as a 2-bit sign/magnitude code. A frame is 120 symbols long. It opens with a 9-symbol synchronization pattern. Twelve channel groups follow, each carrying 8 bits of the first bearer channel, 8 bits of the second bearer channel and 2 bits of the signalling channel. The frame closes with three symbols of maintenance bits. At 80 kbaud a frame lasts 1.5 ms.

All group and maintenance bits pass through a self-synchronizing scrambler before they are paired into symbols. The scrambler taps depend on which end of the line the block serves. The synchronization pattern is sent unscrambled. The first frame of every superframe of eight carries the sign-inverted pattern. Upstream logic holds each group's bits stable for the nine symbols of that group's slot and uses the frame and superframe strobes to keep in step. Downstream logic turns the codes into line levels.

Top module: `quat_tx_framer`

## Requirements
- R1: A synchronous active-high `rst` clears `sym_code`, `sym_valid`, `frame_start` and `sf_start` to 0, zeroes the 23-bit scrambler history, and returns to symbol 0 of frame 0. The first symbol emitted after reset is therefore the first symbol of an inverted pattern that opens a superframe.
- R2: Each cycle with `sym_en` high produces one symbol. Its code and strobes appear in the following cycle, with `sym_valid` high for exactly that cycle. Cycles without `sym_en` do not advance the frame position or the scrambler, and leave `sym_valid` low.
- R3: A frame has 120 symbols: positions 0-8 are the pattern, positions 9+9g to 17+9g carry group g (g = 0..11), and positions 117-119 carry maintenance bits.
- R4: `sym_code` = {sign, magnitude}, with codes 2'b10 = +3, 2'b11 = +1, 2'b01 = -1 and 2'b00 = -3. Inside a group the 18 bits are sent in the order b1_bits[7]..b1_bits[0], b2_bits[7]..b2_bits[0], d_bits[1], d_bits[0]. Each pair of consecutive bits forms one symbol, with the earlier bit as sign. Maintenance symbols take m_bits[5:4], m_bits[3:2] and m_bits[1:0] in that order.
- R5: The pattern symbols are +3,+3,-3,-3,-3,+3,-3,+3,+3 (codes 10,10,00,00,00,10,00,10,10). They are never scrambled.
- R6: In frame 0 of each superframe of 8 frames, every pattern symbol has its sign inverted, giving -3,-3,+3,+3,+3,-3,+3,-3,-3.
- R7: With `lt_mode` = 1, each scrambled bit equals the raw bit XOR the scrambled bit 5 bits earlier XOR the scrambled bit 23 bits earlier.
- R8: With `lt_mode` = 0, each scrambled bit equals the raw bit XOR the scrambled bit 18 bits earlier XOR the scrambled bit 23 bits earlier.
- R9: The scrambler history advances by two bits for each group or maintenance symbol and holds during pattern symbols. The maintenance bits are scrambled like group bits.
- R10: `frame_start` is high with the first pattern symbol of every frame. `sf_start` is high only with the first pattern symbol of frame 0 of a superframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_en | input | 1 | One-cycle pulse per symbol period |
| lt_mode | input | 1 | 1 selects line-side scrambler taps, 0 the customer-side taps |
| b1_bits | input | 8 | First bearer channel bits of the current group |
| b2_bits | input | 8 | Second bearer channel bits of the current group |
| d_bits | input | 2 | Signalling channel bits of the current group |
| m_bits | input | 6 | Maintenance bits of the current frame |
| sym_code | output | 2 | Symbol code {sign, magnitude} |
| sym_valid | output | 1 | High for one cycle when a new symbol is on `sym_code` |
| frame_start | output | 1 | Marks the first symbol of a frame |
| sf_start | output | 1 | Marks the first symbol of a superframe |

## Verification
The hardest behaviour to reach from the ports is the scrambler state at a superframe boundary. By then 23 bits of history depend on hundreds of earlier symbols, including the frozen pattern intervals, so a wrong tap or a history that advances during the pattern shows up only after many frames. The stimulus runs each tap set for more than a full superframe, with several bit patterns, and compares every symbol against an independent bit-serial model. It spaces symbol enables with idle cycles, so any advance without `sym_en` would break the alignment.

// File: rtl/quat_tx_framer.sv
module quat_tx_framer #(
  parameter int SF_FRAMES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_en,
  input  logic       lt_mode,
  input  logic [7:0] b1_bits,
  input  logic [7:0] b2_bits,
  input  logic [1:0] d_bits,
  input  logic [5:0] m_bits,
  output logic [1:0] sym_code,
  output logic       sym_valid,
  output logic       frame_start,
  output logic       sf_start
);

  localparam int FW = (SF_FRAMES > 1) ? $clog2(SF_FRAMES) : 1;
  localparam logic [FW-1:0] LAST_FRM = FW'(SF_FRAMES - 1);
  localparam logic [8:0] SYNC_SIGN = 9'b110001011;
  localparam logic [3:0] MAINT_SLOT = 4'd13;

  logic [3:0]    sub, slot;
  logic [FW-1:0] frm;
  logic [22:0]   scr;

  logic        in_sync, in_maint, last_sym, sync_sign;
  logic [17:0] grp;
  logic [4:0]  gidx;
  logic [2:0]  midx;
  logic        raw0, raw1, s0, s1;

  assign in_sync   = (slot == 4'd0);
  assign in_maint  = (slot == MAINT_SLOT);
  assign last_sym  = in_maint && (sub == 4'd2);
  assign grp       = {b1_bits, b2_bits, d_bits};
  assign gidx      = 5'd17 - {sub, 1'b0};
  assign midx      = 3'd5 - {sub[1:0], 1'b0};
  assign raw0      = in_maint ? m_bits[midx] : grp[gidx];
  assign raw1      = in_maint ? m_bits[midx - 3'd1] : grp[gidx - 5'd1];
  assign s0        = raw0 ^ (lt_mode ? scr[4] : scr[17]) ^ scr[22];
  assign s1        = raw1 ^ (lt_mode ? scr[3] : scr[16]) ^ scr[21];
  assign sync_sign = SYNC_SIGN[4'd8 - sub] ^ (frm == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sub <= '0; slot <= '0; frm <= '0; scr <= '0;
      sym_code <= '0; sym_valid <= 1'b0;
      frame_start <= 1'b0; sf_start <= 1'b0;
    end else begin
      sym_valid   <= sym_en;
      frame_start <= 1'b0;
      sf_start    <= 1'b0;
      if (sym_en) begin
        sym_code    <= in_sync ? {sync_sign, 1'b0} : {s0, s1};
        frame_start <= in_sync && (sub == 4'd0);
        sf_start    <= in_sync && (sub == 4'd0) && (frm == '0);
        if (!in_sync) scr <= {scr[20:0], s0, s1};
        if (last_sym) begin
          sub  <= '0;
          slot <= '0;
          frm  <= (frm == LAST_FRM) ? '0 : frm + 1'b1;
        end else if (sub == 4'd8) begin
          sub  <= '0;
          slot <= slot + 4'd1;
        end else begin
          sub <= sub + 4'd1;
        end
      end
    end
  end

  p_sf_in_frame_r10: assert property (@(posedge clk) disable iff (rst)
    sf_start |-> frame_start);
  p_strobe_valid_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> sym_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !sym_en |=> !sym_valid);
  p_sync_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (sym_en && in_sync) |=> $stable(scr));
  p_isw_first_r6: assert property (@(posedge clk) disable iff (rst)
    sf_start |-> (sym_code == 2'b00));
  p_sw_first_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !sf_start) |-> (sym_code == 2'b10));
  p_pos_range_r3: assert property (@(posedge clk) disable iff (rst)
    (slot <= MAINT_SLOT) && (sub <= 4'd8));

endmodule

// File: tb/quat_tx_framer_bench.sv
`timescale 1ns/1ps
module quat_tx_framer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_en = 1'b0;
  logic       lt_mode = 1'b1;
  logic [7:0] b1_bits = '0, b2_bits = '0;
  logic [1:0] d_bits = '0;
  logic [5:0] m_bits = '0;
  logic [1:0] sym_code;
  logic       sym_valid, frame_start, sf_start;

  always #2.5 clk = ~clk;

  quat_tx_framer u_quat_tx_framer (
    .clk(clk), .rst(rst), .sym_en(sym_en), .lt_mode(lt_mode),
    .b1_bits(b1_bits), .b2_bits(b2_bits), .d_bits(d_bits), .m_bits(m_bits),
    .sym_code(sym_code), .sym_valid(sym_valid),
    .frame_start(frame_start), .sf_start(sf_start)
  );

  // {lt_mode, b1, b2, d, m}
  localparam int NV = 4;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'h00, 2'b00, 6'h00},
    {1'b0, 8'h00, 8'h00, 2'b00, 6'h00},
    {1'b1, 8'hA5, 8'h3C, 2'b10, 6'h2D},
    {1'b0, 8'hFF, 8'h81, 2'b01, 6'h3F}
  };
  localparam logic [8:0] SW = 9'b110001011;

  int checks = 0, failures = 0;
  bit done = 0;
  int pos, frm;
  logic [22:0] bm;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; sym_en = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    pos = 0; frm = 0; bm = '0;
  endtask

  function automatic logic scr_bit(input logic raw, input bit lt);
    logic o;
    o = raw ^ bm[lt ? 4 : 17] ^ bm[22];
    bm = {bm[21:0], o};
    return o;
  endfunction

  task automatic step_and_check();
    int slot, sub, gi;
    logic [17:0] g;
    logic [1:0] exp;
    logic r0, r1, a, b;
    slot = pos / 9; sub = pos % 9;
    g = {b1_bits, b2_bits, d_bits};
    if (slot == 0) begin
      exp = {SW[8 - sub] ^ (frm == 0), 1'b0};
    end else begin
      if (slot == 13) begin r0 = m_bits[5 - 2*sub]; r1 = m_bits[4 - 2*sub]; end
      else begin gi = 17 - 2*sub; r0 = g[gi]; r1 = g[gi - 1]; end
      a = scr_bit(r0, lt_mode);
      b = scr_bit(r1, lt_mode);
      exp = {a, b};
    end
    @(negedge clk); sym_en = 1'b1;
    @(negedge clk); sym_en = 1'b0;
    if (slot == 0) check(sym_code == exp, frm == 0 ? "R6 inverted pattern" : "R5 pattern", sym_code, exp);
    else if (slot == 13) check(sym_code == exp, "R9 maintenance", sym_code, exp);
    else check(sym_code == exp, lt_mode ? "R7 R3 R4 payload" : "R8 R3 R4 payload", sym_code, exp);
    check({sym_valid, frame_start, sf_start} == {1'b1, pos == 0, pos == 0 && frm == 0},
          "R10 R2 strobes", {sym_valid, frame_start, sf_start},
          {1'b1, pos == 0, pos == 0 && frm == 0});
    @(negedge clk);
    check(sym_valid == 1'b0, "R2 idle valid", sym_valid, 0);
    pos++;
    if (pos == 120) begin pos = 0; frm = (frm + 1) % 8; end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    check({sym_code, sym_valid, frame_start, sf_start} == 5'b0, "R1 reset outputs",
          {sym_code, sym_valid, frame_start, sf_start}, 0);

    for (int v = 0; v < NV; v++) begin
      {lt_mode, b1_bits, b2_bits, d_bits, m_bits} = VEC[v];
      do_reset();
      for (int s = 0; s < 1000; s++) step_and_check();
    end

    // R2: long idle gap does not advance position
    lt_mode = 1'b1; b1_bits = 8'h5A; b2_bits = 8'hC3; d_bits = 2'b11; m_bits = 6'h15;
    do_reset();
    for (int s = 0; s < 130; s++) begin
      step_and_check();
      if (s % 37 == 0) repeat (7) @(negedge clk);
    end

    // R1: reset in mid-frame restarts at superframe pattern with cleared scrambler
    for (int s = 0; s < 50; s++) step_and_check();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check({sym_code, sym_valid, frame_start, sf_start} == 5'b0, "R1 mid-run reset",
          {sym_code, sym_valid, frame_start, sf_start}, 0);
    rst = 1'b0; pos = 0; frm = 0; bm = '0;
    for (int s = 0; s < 250; s++) step_and_check();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule